// File: doc/BRIEF.md
# Dual Shift Register SPI Slave

This block is a byte-wide SPI slave built from two independent registers that an external SPI master drives. On the receive side, bits from the master enter a receive shift register on SCK. A separate latch strobe from the master copies that register into a holding register. The host reads the holding register over a parallel bus. On the transmit side, a host bus write loads the transmit byte in parallel. The master then clocks that byte out on MISO with its own SCK.

The master always owns SCK; the block never generates it. The protocol is SPI mode 0, MSB first: MOSI is sampled on the rising SCK edge, and the next MISO bit appears after each falling edge. SCK, MOSI and the latch strobe each pass through a two-flop synchronizer, and their edges are detected in the system clock domain. The host write strobe is taken as synchronous to the system clock.

The transmit side is a three-state machine:

- **ST_IDLE** waits for a frame. It copies the host byte into the shift register.
- **ST_SHIFT** shifts on each falling SCK edge and counts rising edges.
- **ST_TAIL** waits for the falling edge that closes the frame.

Its transitions are:

- **GO_START**: ST_IDLE to ST_SHIFT on the first rising edge.
- **GO_TAIL**: ST_SHIFT to ST_TAIL on the eighth rising edge.
- **GO_DONE**: ST_TAIL to ST_IDLE on the next falling edge.
- Every other case holds the current state.

Top module: `dual_sreg_spi_slave`

## Requirements
- R1: After reset the holding register reads 0x00, the transmit byte is 0x00 and MISO is 0.
- R2: On each rising SCK edge the receive shift register takes in one MOSI bit. Bits enter at the LSB and move toward the MSB, so after 8 edges bit 7 holds the first bit sent.
- R3: The holding register changes only on a rising edge of the latch strobe, when it takes the receive shift register's value. Shifting without a strobe leaves the host read value unchanged.
- R4: A host write strobe stores its byte as the transmit byte. Before the first rising SCK edge of a frame, MISO shows bit 7. After each falling edge it shows the next lower bit, so the master reads the byte MSB first.
- R5: A host write made while a frame is shifting does not change the bits still to be sent in that frame. The new byte is sent in the next frame.
- R6: A frame is 8 rising SCK edges plus the falling edge that follows the last one; the machine then returns to ST_IDLE. With no new host write, the same transmit byte is sent again in the next frame.
- R7: Receive and transmit work in the same frame without affecting each other (full duplex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_latch | input | 1 | Master strobe that copies the receive register into the holding register |
| spi_miso | output | 1 | Serial data to the master |
| host_wr_stb | input | 1 | One-cycle host write strobe, synchronous to clk |
| host_wr_data | input | 8 | Byte loaded into the transmit register |
| host_rd_data | output | 8 | Holding register contents for host reads |

## Verification
The assertions assume the following about the inputs:

- SCK toggles no faster than a quarter of the system clock, and is low between frames.
- Each frame has exactly eight SCK pulses.
- The latch strobe is pulsed only between frames.

The bench holds each SCK phase for eight system clocks and returns SCK low after every byte. It raises the latch strobe only after a frame has fully closed, and it drives all inputs on the falling system clock edge.

// File: rtl/dsss_pkg.sv
package dsss_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } tx_state_t;
endpackage

// File: rtl/dsss_sync.sv
module dsss_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] last;

    for (genvar g = 0; g < STAGES; g++) begin : stg
        logic [W-1:0] r;
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= '0;
                else        r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= '0;
                else        r <= stg[g-1].r;
            end
        end
    end

    assign q = stg[STAGES-1].r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= '0;
        else        last <= q;
    end

    assign rise = q & ~last;
    assign fall = ~q & last;
endmodule

// File: rtl/dsss_rx.sv
module dsss_rx #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_rise,
    input  logic          mosi,
    input  logic          latch_rise,
    output logic [DW-1:0] hold
);
    logic [DW-1:0] rx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rx_sh <= '0;
        else if (sck_rise) rx_sh <= {rx_sh[DW-2:0], mosi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          hold <= '0;
        else if (latch_rise) hold <= rx_sh;
    end

    // R2: the receive register moves only on a rising SCK edge
    a_r2_rx_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_rise |=> $stable(rx_sh));

    // R3: the holding register changes only after a latch strobe edge
    a_r3_hold_only_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_rise |=> $stable(hold));
endmodule

// File: rtl/dsss_tx.sv
module dsss_tx
    import dsss_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_data,
    output logic          miso
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST_CNT = CW'(DW - 1);

    tx_state_t     state, state_nx;
    logic [CW-1:0] cnt;
    logic [DW-1:0] tx_next;
    logic [DW-1:0] tx_sh;

    // host byte, independent of the SPI side
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tx_next <= '0;
        else if (wr_stb) tx_next <= wr_data;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (sck_rise)                     state_nx = ST_SHIFT;  // GO_START
            ST_SHIFT: if (sck_rise && cnt == LAST_CNT)  state_nx = ST_TAIL;   // GO_TAIL
            ST_TAIL:  if (sck_fall)                     state_nx = ST_IDLE;   // GO_DONE
            default:                                    state_nx = ST_IDLE;
        endcase
    end

    // outputs: shift register and edge counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    tx_sh <= tx_next;
                    cnt   <= sck_rise ? CW'(1) : '0;
                end
                ST_SHIFT: begin
                    if (sck_fall) tx_sh <= {tx_sh[DW-2:0], 1'b0};
                    if (sck_rise) cnt <= cnt + CW'(1);
                end
                ST_TAIL: begin
                    cnt <= '0;
                end
                default: begin
                    tx_sh <= '0;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign miso = tx_sh[DW-1];

    // R5: inside a frame the byte in flight moves only on a falling SCK edge
    a_r5_inflight_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !sck_fall) |=> $stable(tx_sh));

    // R6: the idle state always has a cleared edge counter
    a_r6_idle_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (cnt == '0));

    // R6: a frame closes only through the tail state
    a_r6_close_via_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) != ST_IDLE) |-> ($past(state) == ST_TAIL));

    // R4: in idle the shift register follows the host byte
    a_r4_idle_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |=> (tx_sh == $past(tx_next)));
endmodule

// File: rtl/dual_sreg_spi_slave.sv
module dual_sreg_spi_slave #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sck,
    input  logic          spi_mosi,
    input  logic          spi_latch,
    output logic          spi_miso,
    input  logic          host_wr_stb,
    input  logic [DW-1:0] host_wr_data,
    output logic [DW-1:0] host_rd_data
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] s_q, s_rise, s_fall;

    dsss_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({spi_latch, spi_mosi, spi_sck}),
        .q    (s_q),
        .rise (s_rise),
        .fall (s_fall)
    );

    dsss_rx #(.DW(DW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (s_rise[0]),
        .mosi      (s_q[1]),
        .latch_rise(s_rise[2]),
        .hold      (host_rd_data)
    );

    dsss_tx #(.DW(DW)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_rise(s_rise[0]),
        .sck_fall(s_fall[0]),
        .wr_stb (host_wr_stb),
        .wr_data(host_wr_data),
        .miso   (spi_miso)
    );

    // R1: leaving reset, the host read value and MISO are zero
    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (host_rd_data == '0 && spi_miso == 1'b0));
endmodule

// File: tb/sim_dual_sreg_spi_slave.sv
`timescale 1ns/1ps
module sim_dual_sreg_spi_slave;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, mosi = 1'b0, latch = 1'b0;
    logic       miso;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dual_sreg_spi_slave u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi),
        .spi_latch(latch), .spi_miso(miso), .host_wr_stb(wr_stb),
        .host_wr_data(wr_data), .host_rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
        wait_clk(4);
    endtask

    task automatic pulse_latch();
        @(negedge clk); latch = 1'b1;
        wait_clk(HALF);
        latch = 1'b0;
        wait_clk(HALF);
    endtask

    // one frame; optional host write injected after rising edge number inj_at
    task automatic xfer(input logic [7:0] dout, output logic [7:0] din,
                        input bit inj, input int inj_at, input logic [7:0] inj_d);
        din = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk); mosi = dout[i];
            wait_clk(HALF);
            din[i] = miso;
            sck = 1'b1;
            if (inj && (7 - i) == inj_at) begin
                @(negedge clk); wr_stb = 1'b1; wr_data = inj_d;
                @(negedge clk); wr_stb = 1'b0;
                wait_clk(HALF - 2);
            end else begin
                wait_clk(HALF);
            end
            sck = 1'b0;
        end
        wait_clk(HALF);
    endtask

    task automatic t_reset();
        chk("R1 hold", rd_data, 8'h00);
        chk("R1 miso", {7'd0, miso}, 8'h00);
    endtask

    task automatic t_rx_basic();
        logic [7:0] r;
        xfer(8'hA5, r, 1'b0, 0, 8'h00);
        chk("R1 tx byte zero", r, 8'h00);
        pulse_latch();
        chk("R2 rx A5", rd_data, 8'hA5);
        xfer(8'h01, r, 1'b0, 0, 8'h00);
        pulse_latch();
        chk("R2 rx 01", rd_data, 8'h01);
    endtask

    task automatic t_latch_only();
        logic [7:0] r;
        xfer(8'h3C, r, 1'b0, 0, 8'h00);
        chk("R3 hold kept without latch", rd_data, 8'h01);
        pulse_latch();
        chk("R3 hold after latch", rd_data, 8'h3C);
    endtask

    task automatic t_tx_basic();
        logic [7:0] r;
        host_write(8'h96);
        chk("R4 msb before first edge", {7'd0, miso}, 8'h01);
        xfer(8'h00, r, 1'b0, 0, 8'h00);
        chk("R4 tx 96", r, 8'h96);
        host_write(8'h01);
        xfer(8'h00, r, 1'b0, 0, 8'h00);
        chk("R4 tx 01", r, 8'h01);
    endtask

    task automatic t_write_inflight();
        logic [7:0] r;
        host_write(8'h5A);
        xfer(8'h00, r, 1'b1, 3, 8'hC3);
        chk("R5 in-flight byte intact", r, 8'h5A);
        xfer(8'h00, r, 1'b0, 0, 8'h00);
        chk("R5 new byte next frame", r, 8'hC3);
    endtask

    task automatic t_repeat();
        logic [7:0] r;
        xfer(8'h00, r, 1'b0, 0, 8'h00);
        chk("R6 byte repeats", r, 8'hC3);
        host_write(8'h80);
        xfer(8'h00, r, 1'b0, 0, 8'h00);
        chk("R6 frame realigned", r, 8'h80);
    endtask

    task automatic t_duplex();
        logic [7:0] r;
        host_write(8'h7E);
        xfer(8'h81, r, 1'b0, 0, 8'h00);
        pulse_latch();
        chk("R7 duplex tx", r, 8'h7E);
        chk("R7 duplex rx", rd_data, 8'h81);
    endtask

    initial begin
        wait_clk(5);
        t_reset();
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_rx_basic();
        t_latch_only();
        t_tx_basic();
        t_write_inflight();
        t_repeat();
        t_duplex();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule